// File: doc/BRIEF.md
# Configuration Image Byte Loader

This block copies a configuration image from a byte-addressed source into the single-byte configuration port of a programmable target. A start pulse begins the load. The block first holds the target in reset for a fixed number of cycles and lets it settle. It then writes one zero byte and waits a second settle interval. Next it fetches a 16-byte header, streams the payload that the header announces, and appends five zero pad bytes. Finally it samples the target's error line.

The source is read through an address plus a request/acknowledge handshake, so any bridge that returns bytes with a variable latency can feed it. While a load runs, the interrupt enable pattern is held at zero. A load ends in one of two ways. On success the block waits a last settle interval, drives the enable pattern 0x43 and raises `done_o`. On failure it raises `err_o` and keeps the enable pattern at zero. The version and date words from the header stay visible on outputs after the load.

Top module: `cfg_image_loader`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `tgt_rst_o`, `cfg_wr_o` and `src_req_o` are low and `irq_en_o` is 0x00.
- R2: A start pulse in idle drives `tgt_rst_o` high for exactly RST_CYCLES cycles. At least SETTLE_CYCLES cycles then pass before the first configuration write.
- R3: The first configuration write carries 0x00. At least SETTLE_CYCLES cycles separate it from the next configuration write.
- R4: If `img_len_i` is below 16, the load ends with `err_o` high. In that case only the leading zero byte is written, `src_req_o` never rises and `irq_en_o` stays 0x00.
- R5: Header bytes at addresses 0..3 give the payload length, most significant byte first. Bytes 4..7 appear on `ver_o` and bytes 8..11 on `date_o`, each with the lowest address as the most significant byte. Bytes 12..15 have no effect.
- R6: The payload bytes are read from addresses 16 upward. Exactly as many bytes as the length field gives are written, in address order, each once, whatever the acknowledge latency of the source.
- R7: Exactly five 0x00 bytes are written directly after the last payload byte. A zero-length payload is therefore followed by the pad bytes alone.
- R8: `irq_en_o` is 0x00 whenever `busy_o` is high. Bit 5 of `irq_stat_i` is sampled in the cycle after the last pad byte appears. If that bit is set, the load ends with `err_o` high and `irq_en_o` stays 0x00. The other bits of `irq_stat_i` have no effect.
- R9: On success, `irq_en_o` becomes 0x43 and `done_o` rises no earlier than SETTLE_CYCLES cycles after the last pad write.
- R10: `busy_o` is high from the cycle after start until `done_o` or `err_o` rises, and never both of those are high. A start pulse during a load has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a load (single-cycle pulse) |
| img_len_i | input | LEN_W | Total number of bytes available in the image |
| src_req_o | output | 1 | Read request to the image source |
| src_addr_o | output | AW | Byte address of the requested byte |
| src_ack_i | input | 1 | Source has `src_data_i` valid for the current address |
| src_data_i | input | 8 | Byte returned by the source |
| tgt_rst_o | output | 1 | Reset to the configurable target |
| cfg_wr_o | output | 1 | Write strobe to the configuration port |
| cfg_data_o | output | 8 | Byte written to the configuration port |
| irq_stat_i | input | 8 | Interrupt status of the target; bit 5 flags a load error |
| irq_en_o | output | 8 | Interrupt enable pattern (0x00 while disabled, 0x43 after success) |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load succeeded |
| err_o | output | 1 | Last load failed |
| ver_o | output | 32 | Version word from the header |
| date_o | output | 32 | Date word from the header |

## Verification
The bench drives an image source that stalls the acknowledge on a set pattern. A loader that wrote a byte per request instead of per acknowledge would then duplicate or skip payload bytes. A zero-length payload checks that no stray payload byte leaks in before the pad bytes. A short image checks that no header read or extra write happens, which a design checking the length too late would break. An asserted error bit is sent together with a status word that has every other bit set. A design that tested the wrong bit, or enabled interrupts on failure, would then report the wrong outcome. The bench also measures the reset pulse width and the settle gaps in cycles, and it restarts mid-load to catch a loader that re-enters its sequence.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
   localparam int HDR_BYTES   = 16;
   localparam int FIELD_BYTES = 4;
   localparam int NUM_FIELDS  = 3;   // length, version, date
   localparam int PAD_BYTES   = 5;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RST,
      ST_SETTLE_A,
      ST_SETTLE_B,
      ST_CHECK,
      ST_HDR,
      ST_PAY,
      ST_PAD,
      ST_SAMPLE,
      ST_SETTLE_C
   } ld_state_e;
endpackage

// File: rtl/cfg_settle_timer.sv
module cfg_settle_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] count_i,   // number of cycles to wait, >= 1
   output logic          zero_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (load_i)      cnt_q <= count_i - 1'b1;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // R2
   timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && count_i > 1) |=> !zero_o);
endmodule

// File: rtl/cfg_hdr_capture.sv
module cfg_hdr_capture
   import cfg_loader_pkg::*;
#(
   parameter int FW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld_i,
   input  logic [3:0]    idx_i,
   input  logic [7:0]    byte_i,
   output logic [FW-1:0] len_o,
   output logic [FW-1:0] ver_o,
   output logic [FW-1:0] date_o
);
   logic [FW-1:0] fld_q [NUM_FIELDS];

   initial begin
      if (FW != 8*FIELD_BYTES) $error("field width must be four bytes");
   end

   // Each field collects four bytes, lowest address in the top byte.
   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            fld_q[f] <= '0;
         else if (vld_i && idx_i[3:2] == f[1:0])
            fld_q[f][8*(3-int'(idx_i[1:0])) +: 8] <= byte_i;
      end
   end

   assign len_o  = fld_q[0];
   assign ver_o  = fld_q[1];
   assign date_o = fld_q[2];
endmodule

// File: rtl/cfg_port_driver.sv
module cfg_port_driver (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_i,
   input  logic [7:0] data_i,
   output logic       wr_o,
   output logic [7:0] data_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_o   <= 1'b0;
         data_o <= 8'h00;
      end else begin
         wr_o <= wr_i;
         if (wr_i) data_o <= data_i;
      end
   end

   // R3
   port_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(data_o));
endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
   import cfg_loader_pkg::*;
#(
   parameter int AW            = 16,
   parameter int LEN_W         = 32,
   parameter int RST_CYCLES    = 8,
   parameter int SETTLE_CYCLES = 64,
   parameter int ERR_BIT       = 5,
   parameter logic [7:0] IRQ_ON = 8'h43
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LEN_W-1:0] img_len_i,
   output logic             src_req_o,
   output logic [AW-1:0]    src_addr_o,
   input  logic             src_ack_i,
   input  logic [7:0]       src_data_i,
   output logic             tgt_rst_o,
   output logic             cfg_wr_o,
   output logic [7:0]       cfg_data_o,
   input  logic [7:0]       irq_stat_i,
   output logic [7:0]       irq_en_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o,
   output logic [31:0]      ver_o,
   output logic [31:0]      date_o
);
   localparam int TMAX = (RST_CYCLES > SETTLE_CYCLES) ? RST_CYCLES : SETTLE_CYCLES;
   localparam int CW   = $clog2(TMAX + 1);
   localparam int PCW  = $clog2(PAD_BYTES);

   if (RST_CYCLES < 1)    begin : g_bad_rst    $error("RST_CYCLES must be at least 1");    end
   if (SETTLE_CYCLES < 1) begin : g_bad_settle $error("SETTLE_CYCLES must be at least 1"); end
   if (AW < 5)            begin : g_bad_aw     $error("AW must cover the header");         end
   if (ERR_BIT > 7)       begin : g_bad_bit    $error("ERR_BIT must index a status byte"); end

   ld_state_e       st_q;
   logic [31:0]     pay_cnt_q;
   logic [PCW-1:0]  pad_cnt_q;
   logic [AW-1:0]   addr_q;
   logic            tmr_load, tmr_zero;
   logic [CW-1:0]   tmr_count;
   logic            wr_req;
   logic [7:0]      wr_byte;
   logic            hdr_vld;
   logic [31:0]     pay_len;
   logic            pay_left;

   assign pay_left   = (pay_cnt_q != pay_len);
   assign src_addr_o = addr_q;
   assign src_req_o  = (st_q == ST_HDR) || (st_q == ST_PAY && pay_left);
   assign hdr_vld    = (st_q == ST_HDR) && src_ack_i;
   assign tmr_count  = (st_q == ST_IDLE) ? CW'(RST_CYCLES) : CW'(SETTLE_CYCLES);

   always_comb begin
      tmr_load = 1'b0;
      wr_req   = 1'b0;
      wr_byte  = 8'h00;
      unique case (st_q)
         ST_IDLE:     tmr_load = start_i;
         ST_RST:      tmr_load = tmr_zero;
         ST_SETTLE_A: begin
            tmr_load = tmr_zero;
            wr_req   = tmr_zero;        // leading zero byte
         end
         ST_PAY: begin
            wr_req  = pay_left && src_ack_i;
            wr_byte = src_data_i;
         end
         ST_PAD:      wr_req   = 1'b1;
         ST_SAMPLE:   tmr_load = !irq_stat_i[ERR_BIT];
         default:     ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         pay_cnt_q <= '0;
         pad_cnt_q <= '0;
         addr_q    <= '0;
         tgt_rst_o <= 1'b0;
         irq_en_o  <= 8'h00;
         busy_o    <= 1'b0;
         done_o    <= 1'b0;
         err_o     <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               st_q      <= ST_RST;
               tgt_rst_o <= 1'b1;
               busy_o    <= 1'b1;
               done_o    <= 1'b0;
               err_o     <= 1'b0;
               irq_en_o  <= 8'h00;
            end
            ST_RST: if (tmr_zero) begin
               tgt_rst_o <= 1'b0;
               st_q      <= ST_SETTLE_A;
            end
            ST_SETTLE_A: if (tmr_zero) st_q <= ST_SETTLE_B;
            ST_SETTLE_B: if (tmr_zero) st_q <= ST_CHECK;
            ST_CHECK: begin
               addr_q    <= '0;
               pay_cnt_q <= '0;
               pad_cnt_q <= '0;
               if (img_len_i < LEN_W'(HDR_BYTES)) begin
                  err_o  <= 1'b1;
                  busy_o <= 1'b0;
                  st_q   <= ST_IDLE;
               end else begin
                  st_q <= ST_HDR;
               end
            end
            ST_HDR: if (src_ack_i) begin
               addr_q <= addr_q + 1'b1;
               if (addr_q == AW'(HDR_BYTES - 1)) st_q <= ST_PAY;
            end
            ST_PAY: begin
               if (!pay_left)
                  st_q <= ST_PAD;
               else if (src_ack_i) begin
                  addr_q    <= addr_q + 1'b1;
                  pay_cnt_q <= pay_cnt_q + 1'b1;
               end
            end
            ST_PAD: begin
               pad_cnt_q <= pad_cnt_q + 1'b1;
               if (pad_cnt_q == PCW'(PAD_BYTES - 1)) st_q <= ST_SAMPLE;
            end
            ST_SAMPLE: begin
               if (irq_stat_i[ERR_BIT]) begin
                  err_o  <= 1'b1;
                  busy_o <= 1'b0;
                  st_q   <= ST_IDLE;
               end else begin
                  st_q <= ST_SETTLE_C;
               end
            end
            ST_SETTLE_C: if (tmr_zero) begin
               done_o   <= 1'b1;
               busy_o   <= 1'b0;
               irq_en_o <= IRQ_ON;
               st_q     <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   cfg_settle_timer #(.CW(CW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (tmr_load),
      .count_i (tmr_count),
      .zero_o  (tmr_zero)
   );

   cfg_hdr_capture #(.FW(32)) u_hdr (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (hdr_vld),
      .idx_i  (addr_q[3:0]),
      .byte_i (src_data_i),
      .len_o  (pay_len),
      .ver_o  (ver_o),
      .date_o (date_o)
   );

   cfg_port_driver u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (wr_req),
      .data_i (wr_byte),
      .wr_o   (cfg_wr_o),
      .data_o (cfg_data_o)
   );

   // R8
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (irq_en_o == 8'h00));

   // R10
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

   // R2
   rst_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_rst_o |-> busy_o);

   // R4
   fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> (irq_en_o == 8'h00 && !busy_o));

   // R6
   req_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_req_o |-> (busy_o && !tgt_rst_o));
endmodule

// File: tb/cfg_image_loader_tb.sv
module cfg_image_loader_tb_top;
   localparam int RSTC = 3;
   localparam int SETL = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] img_len_i = 32'd0;
   logic        src_req_o;
   logic [15:0] src_addr_o;
   logic        src_ack_i = 1'b0;
   logic [7:0]  src_data_i = 8'h00;
   logic        tgt_rst_o, cfg_wr_o;
   logic [7:0]  cfg_data_o;
   logic [7:0]  irq_stat_i = 8'h00;
   logic [7:0]  irq_en_o;
   logic        busy_o, done_o, err_o;
   logic [31:0] ver_o, date_o;

   always #2 clk = ~clk;   // 250 MHz

   cfg_image_loader #(.RST_CYCLES(RSTC), .SETTLE_CYCLES(SETL)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .img_len_i(img_len_i),
      .src_req_o(src_req_o), .src_addr_o(src_addr_o), .src_ack_i(src_ack_i),
      .src_data_i(src_data_i), .tgt_rst_o(tgt_rst_o), .cfg_wr_o(cfg_wr_o),
      .cfg_data_o(cfg_data_o), .irq_stat_i(irq_stat_i), .irq_en_o(irq_en_o),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .ver_o(ver_o), .date_o(date_o)
   );

   int tests = 0, fails = 0;
   int cyc = 0;
   // image description for the current scenario
   int cur_len = 0, cur_seed = 0, stall_mod = 0;
   localparam logic [31:0] VER  = 32'hA1B2C3D4;
   localparam logic [31:0] DATE = 32'h20170509;

   // monitor state
   logic [7:0] wdat [0:63];
   int wcyc [0:63];
   int nwr = 0, rst_cnt = 0, rst_last = 0, en_cyc = -1, saw_req = 0, loud = 0;

   function automatic logic [7:0] img_byte(int a);
      logic [31:0] l = cur_len;
      if (a < 4)       return l[8*(3-a) +: 8];
      else if (a < 8)  return VER[8*(7-a) +: 8];
      else if (a < 12) return DATE[8*(11-a) +: 8];
      else if (a < 16) return 8'hE0 ^ 8'(a);
      else             return 8'((a * 29 + cur_seed) & 255);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // source responder and monitor, both away from the active edge
   always @(negedge clk) begin
      cyc++;
      src_ack_i  <= src_req_o && (stall_mod == 0 || (cyc % stall_mod) != 0);
      src_data_i <= img_byte(int'(src_addr_o));
      if (cfg_wr_o && nwr < 64) begin
         wdat[nwr] = cfg_data_o;
         wcyc[nwr] = cyc;
         nwr++;
      end
      if (tgt_rst_o) begin rst_cnt++; rst_last = cyc; end
      if (irq_en_o == 8'h43 && en_cyc < 0) en_cyc = cyc;
      if (src_req_o) saw_req = 1;
      if (busy_o && irq_en_o != 8'h00) loud = 1;
   end

   initial begin
      repeat (100000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   task automatic run_load(input int len, input int ilen, input int stall,
                           input logic [7:0] stat, input bit restart);
      cur_len = len; cur_seed = len * 7 + 3; stall_mod = stall;
      img_len_i = ilen; irq_stat_i = stat;
      nwr = 0; rst_cnt = 0; en_cyc = -1; saw_req = 0; loud = 0;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      if (restart) begin
         repeat (2*SETL + RSTC + 4) @(negedge clk);
         start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      end
      while (!(done_o || err_o)) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic check_stream(input int len, input string req);
      bit ok = (nwr == len + 6);
      chk(ok, req, nwr, len + 6);
      if (ok) begin
         for (int i = 0; i < len; i++)
            chk(wdat[1+i] == img_byte(16 + i), "R6 payload", wdat[1+i], img_byte(16 + i));
         for (int i = 0; i < 5; i++)
            chk(wdat[1+len+i] == 8'h00, "R7 pad", wdat[1+len+i], 0);
      end
   endtask

   task automatic t_reset();
      chk(!busy_o && !done_o && !err_o, "R1 status", {busy_o, done_o, err_o}, 0);
      chk(!tgt_rst_o && !cfg_wr_o && !src_req_o, "R1 strobes",
          {tgt_rst_o, cfg_wr_o, src_req_o}, 0);
      chk(irq_en_o == 8'h00, "R1 irq_en", irq_en_o, 0);
   endtask

   task automatic t_basic();
      run_load(7, 7 + 16, 0, 8'h00, 0);
      chk(rst_cnt == RSTC, "R2 reset width", rst_cnt, RSTC);
      chk(wcyc[0] - rst_last >= SETL, "R2 settle", wcyc[0] - rst_last, SETL);
      chk(wdat[0] == 8'h00, "R3 leading byte", wdat[0], 0);
      chk(wcyc[1] - wcyc[0] >= SETL, "R3 settle", wcyc[1] - wcyc[0], SETL);
      check_stream(7, "R6 count");
      chk(ver_o == VER, "R5 version", ver_o, VER);
      chk(date_o == DATE, "R5 date", date_o, DATE);
      chk(done_o && !err_o, "R9 done", {done_o, err_o}, 2);
      chk(irq_en_o == 8'h43, "R9 irq_en", irq_en_o, 8'h43);
      chk(en_cyc - wcyc[nwr-1] >= SETL, "R9 settle", en_cyc - wcyc[nwr-1], SETL);
      chk(!busy_o, "R10 busy cleared", busy_o, 0);
      chk(!loud, "R8 quiet while busy", loud, 0);
   endtask

   task automatic t_stall();
      run_load(20, 40, 3, 8'h00, 0);
      check_stream(20, "R6 stalled count");
      chk(done_o, "R6 stalled done", done_o, 1);
   endtask

   task automatic t_zero();
      run_load(0, 16, 2, 8'h00, 0);
      check_stream(0, "R7 zero length");
      chk(done_o, "R7 zero done", done_o, 1);
   endtask

   task automatic t_short();
      run_load(5, 10, 0, 8'h00, 0);
      chk(err_o && !done_o, "R4 error", {done_o, err_o}, 1);
      chk(nwr == 1, "R4 writes", nwr, 1);
      chk(saw_req == 0, "R4 no reads", saw_req, 0);
      chk(irq_en_o == 8'h00, "R4 irq_en", irq_en_o, 0);
   endtask

   task automatic t_errline();
      run_load(4, 64, 0, 8'h20, 0);
      chk(err_o && !done_o, "R8 error line", {done_o, err_o}, 1);
      chk(irq_en_o == 8'h00, "R8 irq stays off", irq_en_o, 0);
      chk(nwr == 10, "R8 writes before sample", nwr, 10);
   endtask

   task automatic t_otherbits();
      run_load(3, 64, 0, 8'hDF, 0);
      chk(done_o && !err_o, "R8 other bits ignored", {done_o, err_o}, 2);
      chk(irq_en_o == 8'h43, "R8 other bits irq_en", irq_en_o, 8'h43);
   endtask

   task automatic t_restart();
      run_load(9, 64, 0, 8'h00, 1);
      check_stream(9, "R10 restart ignored");
      chk(rst_cnt == RSTC, "R10 single reset", rst_cnt, RSTC);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_basic();
      t_stall();
      t_zero();
      t_short();
      t_errline();
      t_otherbits();
      t_restart();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule